// File: doc/BRIEF.md
# Free-Running Compare Timer

A memory-mapped general-purpose timer built around an up-counter, one output-compare channel and a level interrupt. Software programs it over a simple word-wide register bus (address, write strobe, write data, combinational read data). Once enabled, the counter advances on single-cycle ticks from one of several sources. These are the bus clock itself, a peripheral tick input, or a crystal tick input that passes through a programmable prescaler.

When the counter steps onto the value held in the compare register, a sticky status flag is raised. That flag, gated by a separate interrupt-enable register, drives the interrupt output. The timer can run in one of two ways. In free-run mode the counter keeps counting past the match and wraps at its full width. In restart mode the counter returns to zero on the tick that follows a match. Both tick inputs are enables in the same clock domain as the bus.

Top module: `tmr_top`

## Requirements
- R1: After reset every register reads as zero, the counter reads zero and `irq` is low.
- R2: Register map by byte offset. Control is at 0x00 and keeps only these bits: bit 0 run, bit 3 wait-run, bits 8:6 tick source, bit 9 free-run, bit 10 crystal-path enable. Prescale is at 0x04 and keeps a 4-bit divider field in bits 15:12. Status is at 0x08 with the match flag in bit 0. Interrupt enable is at 0x0C, bit 0. Compare is at 0x10, 32 bits. The counter reads at 0x24. Bits that are not implemented read as zero.
- R3: With tick source 1 (bus clock) and run set, the counter advances by one on every clock edge. The first step happens on the edge after the write that sets run.
- R4: Tick source 2 advances the counter once per `periph_tick` pulse. Tick source 5 with bit 10 set advances it once per N+1 `xtal_tick` pulses, where N is the prescale field. Source 5 with bit 10 clear, and any other source code, never advance it.
- R5: While `sys_wait` is high, the counter holds unless control bit 3 is set.
- R6: The status flag is set on the tick where the counter moves to a value equal to the compare register.
- R7: In free-run mode the counter keeps counting past a match and wraps modulo 2^32. A compare value below the current count does not raise the flag until the counter wraps.
- R8: With free-run clear, the counter reloads to zero on the tick after it has reached the compare value.
- R9: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged. The flag stays set until it is cleared.
- R10: `irq` is high exactly when the flag is set and interrupt-enable bit 0 is 1. Writing 0 to the enable masks it.
- R11: While run is clear the counter is zero and holds. Writing 0 to control and prescale leaves the block idle, and ticks then have no effect.
- R12: Unmapped offsets read as zero, and writes to them change nothing. Writes to the counter offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the bus clock tick source |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| periph_tick | input | 1 | Peripheral tick, single-cycle enable |
| xtal_tick | input | 1 | Crystal-derived tick, single-cycle enable before prescaling |
| sys_wait | input | 1 | High while the system is in its low-power wait state |
| irq | output | 1 | Level interrupt: match flag AND interrupt enable |

## Verification
The assertions take for granted that `periph_tick` and `xtal_tick` are synchronous single-cycle enables in the `clk` domain. They also assume that a compare write and a match never fall on the same edge in a way that would need the older compare value. The flag check compares against the compare value of the previous cycle, so this holds either way. The stimulus drives every input on the falling edge, makes each tick pulse one cycle long, and never writes the status clear on the edge where a match sets the flag. It also waits whole cycles between register writes and reads, so each expected count follows directly from the number of edges elapsed.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the compare timer.
// Assumes byte offsets fit in the bus address width chosen at the top.
package tmr_pkg;

    localparam int unsigned BUS_W = 32;

    // Register byte offsets decoded by the register block
    localparam int unsigned OFS_CTRL  = 'h00;
    localparam int unsigned OFS_PSC   = 'h04;
    localparam int unsigned OFS_STAT  = 'h08;
    localparam int unsigned OFS_IEN   = 'h0C;
    localparam int unsigned OFS_CMP   = 'h10;
    localparam int unsigned OFS_COUNT = 'h24;

    // Control field positions
    localparam int unsigned CTL_RUN_BIT   = 0;
    localparam int unsigned CTL_WAIT_BIT  = 3;
    localparam int unsigned CTL_SRC_LSB   = 6;
    localparam int unsigned CTL_FREE_BIT  = 9;
    localparam int unsigned CTL_XTAL_BIT  = 10;

    // Prescale field position
    localparam int unsigned PSC_LSB = 12;

    // Tick source codes
    localparam logic [2:0] SRC_BUS    = 3'd1;
    localparam logic [2:0] SRC_PERIPH = 3'd2;
    localparam logic [2:0] SRC_XTAL   = 3'd5;

    typedef struct packed {
        logic       xtal_en;
        logic       free_run;
        logic [2:0] src;
        logic       wait_en;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
// Register file and read mux of the compare timer.
// Assumes one write per cycle; reads are combinational on the address.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PSC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              flag,
    output ctrl_t             ctrl,
    output logic [PSC_W-1:0]  psc_div,
    output logic [CNT_W-1:0]  cmp,
    output logic              ien,
    output logic              flag_clr
);

    logic hit_ctrl, hit_psc, hit_stat, hit_ien, hit_cmp, hit_count;

    // Decode the byte offset into one-hot register hits
    always_comb begin
        hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
        hit_psc   = (addr == ADDR_W'(OFS_PSC));
        hit_stat  = (addr == ADDR_W'(OFS_STAT));
        hit_ien   = (addr == ADDR_W'(OFS_IEN));
        hit_cmp   = (addr == ADDR_W'(OFS_CMP));
        hit_count = (addr == ADDR_W'(OFS_COUNT));
    end

    // Capture writes into the implemented fields only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            psc_div <= '0;
            cmp     <= '0;
            ien     <= 1'b0;
        end else if (we) begin
            if (hit_ctrl) begin
                ctrl.run      <= wdata[CTL_RUN_BIT];
                ctrl.wait_en  <= wdata[CTL_WAIT_BIT];
                ctrl.src      <= wdata[CTL_SRC_LSB +: 3];
                ctrl.free_run <= wdata[CTL_FREE_BIT];
                ctrl.xtal_en  <= wdata[CTL_XTAL_BIT];
            end
            if (hit_psc) psc_div <= wdata[PSC_LSB +: PSC_W];
            if (hit_cmp) cmp     <= wdata[CNT_W-1:0];
            if (hit_ien) ien     <= wdata[0];
        end
    end

    // Write-one-to-clear request for the match flag
    assign flag_clr = we && hit_stat && wdata[0];

    // Read mux; unmapped offsets return zero
    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[CTL_RUN_BIT]       = ctrl.run;
            rdata[CTL_WAIT_BIT]      = ctrl.wait_en;
            rdata[CTL_SRC_LSB +: 3]  = ctrl.src;
            rdata[CTL_FREE_BIT]      = ctrl.free_run;
            rdata[CTL_XTAL_BIT]      = ctrl.xtal_en;
        end
        if (hit_psc)   rdata[PSC_LSB +: PSC_W] = psc_div;
        if (hit_stat)  rdata[0]                = flag;
        if (hit_ien)   rdata[0]                = ien;
        if (hit_cmp)   rdata[CNT_W-1:0]        = cmp;
        if (hit_count) rdata[CNT_W-1:0]        = cnt;
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_ctrl, hit_psc, hit_stat, hit_ien, hit_cmp, hit_count})); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_ctrl | hit_psc | hit_stat | hit_ien | hit_cmp | hit_count) |-> (rdata == '0)); // R12

endmodule

// File: rtl/tmr_tick_sel.sv
// Tick source selection and crystal prescaler.
// Assumes both tick inputs are single-cycle enables in the clk domain.
module tmr_tick_sel
    import tmr_pkg::*;
#(
    parameter int unsigned PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [PSC_W-1:0] psc_div,
    input  logic             periph_tick,
    input  logic             xtal_tick,
    input  logic             sys_wait,
    output logic             tick
);

    logic [PSC_W-1:0] psc_cnt;
    logic             xtal_on;
    logic             xtal_div;
    logic             raw_tick;

    assign xtal_on  = ctrl.run && ctrl.xtal_en;
    assign xtal_div = xtal_on && xtal_tick && (psc_cnt >= psc_div);

    // Count crystal pulses and wrap after N+1 of them
    always_ff @(posedge clk) begin
        if (!rst_n || !xtal_on) begin
            psc_cnt <= '0;
        end else if (xtal_tick) begin
            if (psc_cnt >= psc_div) psc_cnt <= '0;
            else                    psc_cnt <= psc_cnt + PSC_W'(1);
        end
    end

    // Pick the raw tick from the selected source
    always_comb begin
        unique case (ctrl.src)
            SRC_BUS:    raw_tick = 1'b1;
            SRC_PERIPH: raw_tick = periph_tick;
            SRC_XTAL:   raw_tick = xtal_div;
            default:    raw_tick = 1'b0;
        endcase
    end

    // Gate by run and the low-power wait policy
    assign tick = raw_tick && ctrl.run && (!sys_wait || ctrl.wait_en);

    AST_XTAL_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl.src == SRC_XTAL) |-> (xtal_tick && ctrl.xtal_en)); // R4

    AST_PERIPH_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl.src == SRC_PERIPH) |-> periph_tick); // R4

    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sys_wait) |-> ctrl.wait_en); // R5

    AST_PSC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !xtal_on |=> (psc_cnt == '0)); // R11

endmodule

// File: rtl/tmr_core.sv
// Counter, compare and sticky match flag.
// Assumes tick is already gated by run; a set and a clear on the same
// edge leave the flag set.
module tmr_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             free_run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    logic [CNT_W-1:0] cnt_next;
    logic             at_cmp;

    assign at_cmp   = (cnt == cmp);
    assign cnt_next = (!free_run && at_cmp) ? '0 : cnt + CNT_W'(1);

    // Advance the counter on each tick, clear it while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= cnt_next;
    end

    // Raise the flag when the counter steps onto the compare value
    always_ff @(posedge clk) begin
        if (!rst_n)                                     flag <= 1'b0;
        else if (run && tick && (cnt_next == cmp))      flag <= 1'b1;
        else if (flag_clr)                              flag <= 1'b0;
    end

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R11

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt)); // R3

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && free_run) |=> (cnt == $past(cnt) + CNT_W'(1))); // R7

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !free_run && at_cmp) |=> (cnt == '0)); // R8

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == $past(cmp))); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R9

endmodule

// File: rtl/tmr_top.sv
// Free-running compare timer: register bus, tick selection, counter.
// Assumes a single clock domain; tick inputs are one-cycle enables.
module tmr_top
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PSC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              periph_tick,
    input  logic              xtal_tick,
    input  logic              sys_wait,
    output logic              irq
);

    ctrl_t            ctrl;
    logic [PSC_W-1:0] psc_div;
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] cnt;
    logic             ien;
    logic             flag;
    logic             flag_clr;
    logic             tick;

    tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .cnt      (cnt),
        .flag     (flag),
        .ctrl     (ctrl),
        .psc_div  (psc_div),
        .cmp      (cmp),
        .ien      (ien),
        .flag_clr (flag_clr)
    );

    tmr_tick_sel #(.PSC_W(PSC_W)) i_tick_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .psc_div     (psc_div),
        .periph_tick (periph_tick),
        .xtal_tick   (xtal_tick),
        .sys_wait    (sys_wait),
        .tick        (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl.run),
        .free_run (ctrl.free_run),
        .tick     (tick),
        .cmp      (cmp),
        .flag_clr (flag_clr),
        .cnt      (cnt),
        .flag     (flag)
    );

    // Level interrupt from the masked match flag
    assign irq = flag && ien;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bus_addr != ADDR_W'(OFS_STAT) || bus_rdata[0])); // R10

endmodule

// File: tb/test_tmr_top.sv
// Directed bench for the compare timer: one task per scenario.
module test_tmr_top;

    localparam logic [11:0] A_CTRL = 12'h000, A_PSC = 12'h004, A_STAT = 12'h008,
                            A_IEN  = 12'h00C, A_CMP = 12'h010, A_CNT  = 12'h024,
                            A_GAP  = 12'h018;
    localparam logic [31:0] C_BUS_FREE = 32'h241, C_BUS_RST = 32'h041,
                            C_PER_FREE = 32'h281, C_XT_FREE = 32'h741,
                            C_XT_NOEN  = 32'h341, C_BUS_WAIT = 32'h249;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        periph_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        sys_wait = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_top i_tmr_top (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_tick(periph_tick),
        .xtal_tick(xtal_tick), .sys_wait(sys_wait), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_per(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) periph_tick = 1'b1;
            @(negedge clk) periph_tick = 1'b0;
        end
    endtask

    task automatic pulse_xtal(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) xtal_tick = 1'b1;
            @(negedge clk) xtal_tick = 1'b0;
        end
    endtask

    task automatic clean();
        wr(A_CTRL, 0); wr(A_PSC, 0); wr(A_IEN, 0); wr(A_STAT, 1); wr(A_CMP, 32'hFFFF_0000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_PSC, v);  chk("R1 psc", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_IEN, v);  chk("R1 ien", v, 0);
        rd(A_CMP, v);  chk("R1 cmp", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R2 ctrl bits", v, 32'h0000_07C9);
        wr(A_PSC, 32'hFFFF_FFFF);  rd(A_PSC, v);  chk("R2 psc bits", v, 32'h0000_F000);
        wr(A_IEN, 32'hFFFF_FFFF);  rd(A_IEN, v);  chk("R2 ien bits", v, 1);
        wr(A_CMP, 32'hDEAD_BEEF);  rd(A_CMP, v);  chk("R2 cmp", v, 32'hDEAD_BEEF);
        idle(5); rd(A_CNT, v); chk("R4 source 7 no advance", v, 0);
        wr(A_CNT, 32'h55);  rd(A_CNT, v);  chk("R12 count write ignored", v, 0);
        wr(A_GAP, 32'hFFFF); rd(A_GAP, v); chk("R12 unmapped reads zero", v, 0);
        rd(A_CMP, v); chk("R12 unmapped write no effect", v, 32'hDEAD_BEEF);
        clean();
    endtask

    task automatic t_bus_clock();
        logic [31:0] v;
        wr(A_CTRL, C_BUS_FREE); rd(A_CNT, v); chk("R3 first step next edge", v, 0);
        idle(9); rd(A_CNT, v); chk("R3 one per cycle", v, 9);
        wr(A_CTRL, 0); idle(1); rd(A_CNT, v); chk("R11 stop clears", v, 0);
        idle(5); rd(A_CNT, v); chk("R11 stays zero", v, 0);
    endtask

    task automatic t_free_match();
        logic [31:0] v;
        wr(A_IEN, 1); wr(A_CMP, 5); wr(A_CTRL, C_BUS_FREE);
        idle(4); rd(A_STAT, v); chk("R6 no flag before match", v, 0);
        chk("R10 irq low before match", {31'b0, irq}, 0);
        idle(1); rd(A_STAT, v); chk("R6 flag at match", v, 1);
        chk("R10 irq high", {31'b0, irq}, 1);
        idle(3); rd(A_CNT, v); chk("R7 counts past match", v, 8);
        wr(A_IEN, 0); chk("R10 masked", {31'b0, irq}, 0);
        wr(A_STAT, 0); rd(A_STAT, v); chk("R9 write 0 keeps flag", v, 1);
        wr(A_STAT, 1); rd(A_STAT, v); chk("R9 write 1 clears", v, 0);
        wr(A_CMP, 3); idle(50); rd(A_STAT, v); chk("R7 compare below count no fire", v, 0);
        clean();
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(A_CMP, 3); wr(A_CTRL, C_BUS_RST);
        idle(3); rd(A_STAT, v); chk("R6 restart flag", v, 1);
        rd(A_CNT, v); chk("R8 at compare", v, 3);
        idle(1); rd(A_CNT, v); chk("R8 reload zero", v, 0);
        idle(1); rd(A_CNT, v); chk("R8 counts again", v, 1);
        clean();
    endtask

    task automatic t_sources();
        logic [31:0] v;
        wr(A_CTRL, C_PER_FREE); pulse_per(7); rd(A_CNT, v); chk("R4 periph ticks", v, 7);
        pulse_xtal(4); rd(A_CNT, v); chk("R4 xtal ignored on periph", v, 7);
        wr(A_CTRL, 0);
        wr(A_PSC, 32'h7000); wr(A_CTRL, C_XT_FREE);
        pulse_xtal(16); rd(A_CNT, v); chk("R4 xtal div 8", v, 2);
        pulse_xtal(7);  rd(A_CNT, v); chk("R4 xtal partial", v, 2);
        pulse_xtal(1);  rd(A_CNT, v); chk("R4 xtal eighth", v, 3);
        wr(A_PSC, 32'h2000); pulse_xtal(3); rd(A_CNT, v); chk("R4 xtal div 3", v, 4);
        pulse_per(3); rd(A_CNT, v); chk("R4 periph ignored on xtal", v, 4);
        wr(A_CTRL, C_XT_NOEN); pulse_xtal(10); rd(A_CNT, v); chk("R4 xtal path off", v, 4);
        clean();
    endtask

    task automatic t_wait();
        logic [31:0] v;
        sys_wait = 1'b1;
        wr(A_CTRL, C_BUS_FREE); idle(6); rd(A_CNT, v); chk("R5 held in wait", v, 0);
        wr(A_CTRL, C_BUS_WAIT); idle(6); rd(A_CNT, v); chk("R5 wait-run counts", v, 6);
        sys_wait = 1'b0;
        clean();
    endtask

    task automatic t_idle();
        logic [31:0] v;
        wr(A_CTRL, 0); wr(A_PSC, 0);
        pulse_per(3); pulse_xtal(3); idle(4);
        rd(A_CNT, v); chk("R11 idle ignores ticks", v, 0);
        rd(A_STAT, v); chk("R11 idle no flag", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_bus_clock();
        t_free_match();
        t_restart();
        t_sources();
        t_wait();
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule